// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulator on a One-Shot Comparator

This block stands in for a real-time clock's interrupt output when that clock's interrupt line is in use by a system timer. It drives one comparator channel of a free-running counter in one-shot mode. Each time the counter reaches the comparator value, the block records a tick. It then moves the comparator forward for the next tick and decides which of three interrupt sources fired. An update source fires when the seconds have changed. An alarm source fires when the time of day equals a programmed alarm. A periodic source runs at a power-of-two rate from 2 Hz to 8192 Hz.

The base tick runs at 64 Hz, and its comparator step comes from a programmable input. A periodic rate of 64 Hz or lower comes from counting base ticks. A higher periodic rate replaces the comparator step with a second programmable step, and a periodic flag is then raised on every tick. If the counter has already moved past the new comparator value, the block keeps adding the step. Each extra addition counts as a lost tick, and lost ticks feed the periodic count. The time of day comes from outside the block. The result is a 16-bit flag word with a one-cycle strobe.

A controller with five states runs the block:
- OFF: the channel is disabled. It goes to WAIT when any enable is set, and arms the comparator on that step.
- WAIT: the channel is armed. It goes back to OFF when all enables are clear, and goes to STEP when the counter reaches the comparator.
- STEP: adds one step to the comparator, then goes to CHECK.
- CHECK: returns to STEP while the counter is strictly past the comparator, and otherwise goes to FIRE.
- FIRE: judges the sources, emits the flag word, and returns to WAIT.

Top module: `rtc_tick_emulator`

## Requirements
- R1: After reset the comparator channel is disabled (`cmp_enable` = 0) and `flag_valid` is 0.
- R2: When at least one enable input rises while none was set, the channel becomes enabled on the next clock edge with `cmp_value` = `count_now` + step. The step is `fast_step` when `en_periodic` = 1 and `rate_log2` > 6, and `base_step` otherwise.
- R3: When all three enable inputs are 0 while the channel waits for a tick, `cmp_enable` drops to 0.
- R4: A tick is due when (`count_now` − `cmp_value`) taken as a signed 32-bit number is ≥ 0. On a tick the comparator advances by one step. It keeps advancing while the counter is still strictly past it, so a counter that has wrapped is handled correctly. Every advance after the first counts as a lost tick. When no tick is due, `cmp_value` is unchanged.
- R5: With `en_update` = 1, a tick whose `tod_sec` differs from the last recorded seconds sets bit 4 of the flag word and records `tod_sec`. The recorded seconds value resets to 0.
- R6: With `en_alarm` = 1, a tick on which hours, minutes and seconds all equal the alarm inputs sets bit 5 of the flag word. With `en_alarm` = 0 an alarm match has no effect.
- R7: With `en_periodic` = 1 and `rate_log2` = r ≤ 6 (r = 0 is treated as 1), the limit is 2^(6−r). On each tick the count becomes count + lost + 1. When that value reaches the limit, bit 6 is set and the count clears. The count clears while `en_periodic` = 0.
- R8: With `en_periodic` = 1 and `rate_log2` > 6, the comparator step is `fast_step` and bit 6 is set on every tick.
- R9: When a tick sets at least one of bits 4 to 6, `flag_valid` pulses for exactly one cycle. The flag word then has bit 7 = 1 (interrupt pending), bits 15:8 = 1 and bits 3:0 = 0. A tick that sets none of bits 4 to 6 emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_now | input | 32 | Main counter value |
| tod_hour | input | 8 | Current hours |
| tod_min | input | 8 | Current minutes |
| tod_sec | input | 8 | Current seconds |
| en_update | input | 1 | Enables the update source |
| en_alarm | input | 1 | Enables the alarm source |
| en_periodic | input | 1 | Enables the periodic source |
| alarm_hour | input | 8 | Alarm hours |
| alarm_min | input | 8 | Alarm minutes |
| alarm_sec | input | 8 | Alarm seconds |
| rate_log2 | input | 4 | log2 of the periodic rate in Hz (1 to 13) |
| base_step | input | 32 | Comparator step for the 64 Hz base tick |
| fast_step | input | 32 | Comparator step for periodic rates above 64 Hz |
| cmp_value | output | 32 | Comparator value |
| cmp_enable | output | 1 | Comparator channel enable |
| flag_word | output | 16 | Interrupt flag word |
| flag_valid | output | 1 | One-cycle strobe for `flag_word` |

## Verification
The assertions assume that the step inputs stay stable from the moment a tick is detected until the flag word is emitted. Under that condition every comparator change is exactly one step, and arming always uses the counter and step seen on the previous edge. They also assume that a nonzero step is used, so the catch-up loop ends. The catch-up loop reads the counter again on each pass. For that reason the stimulus changes the counter, the time of day and the step inputs only between tick windows, and holds them steady for thirty cycles while the design works. Counter jumps are chosen to cause several lost ticks and a wrap through zero.

// File: rtl/rtc_emu_pkg.sv
`timescale 1ns/1ps
package rtc_emu_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_STEP,
        ST_CHECK,
        ST_FIRE
    } emu_state_t;

    localparam int FLAG_UPD  = 4;
    localparam int FLAG_ALM  = 5;
    localparam int FLAG_PER  = 6;
    localparam int FLAG_PEND = 7;
    localparam int FLAG_W    = 16;
    localparam logic [7:0] SOURCE_COUNT = 8'd1;

endpackage

// File: rtl/rtc_emu_match.sv
`timescale 1ns/1ps
module rtc_emu_match #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_update,
    input  logic          en_alarm,
    input  logic          fire,
    input  logic [TW-1:0] tod_hour,
    input  logic [TW-1:0] tod_min,
    input  logic [TW-1:0] tod_sec,
    input  logic [TW-1:0] alarm_hour,
    input  logic [TW-1:0] alarm_min,
    input  logic [TW-1:0] alarm_sec,
    output logic          update_hit,
    output logic          alarm_hit
);

    logic [TW-1:0] last_sec_q;

    always_comb begin
        update_hit = en_update && (tod_sec != last_sec_q);
        alarm_hit  = en_alarm && (tod_sec == alarm_sec) &&
                     (tod_min == alarm_min) && (tod_hour == alarm_hour);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sec_q <= '0;
        end else if (fire && update_hit) begin
            last_sec_q <= tod_sec;
        end
    end

endmodule

// File: rtl/rtc_emu_divider.sv
`timescale 1ns/1ps
module rtc_emu_divider #(
    parameter int CW        = 32,
    parameter int RW        = 4,
    parameter int BASE_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          fire,
    input  logic [RW-1:0] rate_log2,
    input  logic [CW-1:0] lost,
    output logic          periodic_hit
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] sum;
    int            r_eff;

    always_comb begin
        r_eff = (rate_log2 == '0) ? 1 : int'(rate_log2);
        if (r_eff > BASE_LOG2) begin
            limit = CW'(1);
        end else begin
            limit = CW'(1) << (BASE_LOG2 - r_eff);
        end
        sum          = cnt_q + lost + CW'(1);
        periodic_hit = active && (sum >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= periodic_hit ? '0 : sum;
        end
    end

endmodule

// File: rtl/rtc_tick_emulator.sv
`timescale 1ns/1ps
module rtc_tick_emulator
    import rtc_emu_pkg::*;
#(
    parameter int CW        = 32,
    parameter int TW        = 8,
    parameter int RW        = 4,
    parameter int BASE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_now,
    input  logic [TW-1:0]     tod_hour,
    input  logic [TW-1:0]     tod_min,
    input  logic [TW-1:0]     tod_sec,
    input  logic              en_update,
    input  logic              en_alarm,
    input  logic              en_periodic,
    input  logic [TW-1:0]     alarm_hour,
    input  logic [TW-1:0]     alarm_min,
    input  logic [TW-1:0]     alarm_sec,
    input  logic [RW-1:0]     rate_log2,
    input  logic [CW-1:0]     base_step,
    input  logic [CW-1:0]     fast_step,
    output logic [CW-1:0]     cmp_value,
    output logic              cmp_enable,
    output logic [FLAG_W-1:0] flag_word,
    output logic              flag_valid
);

    emu_state_t        state_q, state_d;
    logic [CW-1:0]     cmp_q;
    logic [CW-1:0]     adds_q;
    logic [CW-1:0]     step_sel;
    logic [CW-1:0]     lag;
    logic [CW-1:0]     lost;
    logic              any_en;
    logic              fast_mode;
    logic              tick_due;
    logic              still_behind;
    logic              fire;
    logic              update_hit;
    logic              alarm_hit;
    logic              periodic_hit;
    logic              any_hit;
    logic [FLAG_W-1:0] word_d;

    // step choice and wrap-safe distance to the comparator
    always_comb begin
        any_en       = en_update || en_alarm || en_periodic;
        fast_mode    = en_periodic && (int'(rate_log2) > BASE_LOG2);
        step_sel     = fast_mode ? fast_step : base_step;
        lag          = count_now - cmp_q;
        tick_due     = !lag[CW-1];
        still_behind = !lag[CW-1] && (lag != '0);
        fire         = (state_q == ST_FIRE);
        lost         = adds_q - CW'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (any_en) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!any_en)       state_d = ST_OFF;
                else if (tick_due) state_d = ST_STEP;
            end
            ST_STEP:  state_d = ST_CHECK;
            ST_CHECK: state_d = still_behind ? ST_STEP : ST_FIRE;
            ST_FIRE:  state_d = ST_WAIT;
            default:  state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // comparator and advance counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            adds_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: if (any_en) cmp_q <= count_now + step_sel;
                ST_WAIT: if (any_en && tick_due) adds_q <= '0;
                ST_STEP: begin
                    cmp_q  <= cmp_q + step_sel;
                    adds_q <= adds_q + CW'(1);
                end
                default: ;
            endcase
        end
    end

    rtc_emu_match #(.TW(TW)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_update  (en_update),
        .en_alarm   (en_alarm),
        .fire       (fire),
        .tod_hour   (tod_hour),
        .tod_min    (tod_min),
        .tod_sec    (tod_sec),
        .alarm_hour (alarm_hour),
        .alarm_min  (alarm_min),
        .alarm_sec  (alarm_sec),
        .update_hit (update_hit),
        .alarm_hit  (alarm_hit)
    );

    rtc_emu_divider #(.CW(CW), .RW(RW), .BASE_LOG2(BASE_LOG2)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (en_periodic),
        .fire         (fire),
        .rate_log2    (rate_log2),
        .lost         (lost),
        .periodic_hit (periodic_hit)
    );

    always_comb begin
        any_hit             = update_hit || alarm_hit || periodic_hit;
        word_d              = '0;
        word_d[15:8]        = SOURCE_COUNT;
        word_d[FLAG_PEND]   = 1'b1;
        word_d[FLAG_UPD]    = update_hit;
        word_d[FLAG_ALM]    = alarm_hit;
        word_d[FLAG_PER]    = periodic_hit;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_valid <= 1'b0;
            flag_word  <= '0;
        end else begin
            flag_valid <= fire && any_hit;
            if (fire && any_hit) flag_word <= word_d;
        end
    end

    assign cmp_value  = cmp_q;
    assign cmp_enable = (state_q != ST_OFF);

endmodule

// File: rtl/rtc_emu_checker.sv
`timescale 1ns/1ps
module rtc_emu_checker #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count_now,
    input logic [CW-1:0] step_sel,
    input logic [CW-1:0] cmp_value,
    input logic          cmp_enable,
    input logic          en_update,
    input logic          en_alarm,
    input logic          en_periodic,
    input logic [15:0]   flag_word,
    input logic          flag_valid
);

    // R2: arming value is counter plus step seen on the arming edge
    p_arm_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_enable) |-> cmp_value == $past(count_now) + $past(step_sel));

    // R2: channel only turns on because an enable was set
    p_arm_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_enable) |-> $past(en_update || en_alarm || en_periodic));

    // R3: channel only turns off with every enable clear
    p_off_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_enable) |-> $past(!(en_update || en_alarm || en_periodic)));

    // R3: an off channel with no enable stays off
    p_stay_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_enable && !(en_update || en_alarm || en_periodic)) |=> !cmp_enable);

    // R4: while enabled, the comparator only moves by one step
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_enable && $past(cmp_enable) && cmp_value != $past(cmp_value))
        |-> cmp_value == $past(cmp_value) + $past(step_sel));

    // R9: strobe lasts one cycle
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |=> !flag_valid);

    // R9: flag word layout
    p_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |-> (flag_word[15:8] == 8'd1) && flag_word[7] &&
                       (|flag_word[6:4]) && (flag_word[3:0] == 4'd0));

endmodule

bind rtc_tick_emulator rtc_emu_checker #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_now   (count_now),
    .step_sel    (step_sel),
    .cmp_value   (cmp_value),
    .cmp_enable  (cmp_enable),
    .en_update   (en_update),
    .en_alarm    (en_alarm),
    .en_periodic (en_periodic),
    .flag_word   (flag_word),
    .flag_valid  (flag_valid)
);

// File: tb/sim_rtc_tick_emulator.sv
`timescale 1ns/1ps
module sim_rtc_tick_emulator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] count_now = '0;
    logic [7:0]  tod_hour = '0, tod_min = '0, tod_sec = '0;
    logic        en_update = 1'b0, en_alarm = 1'b0, en_periodic = 1'b0;
    logic [7:0]  alarm_hour = '0, alarm_min = '0, alarm_sec = '0;
    logic [3:0]  rate_log2 = 4'd1;
    logic [31:0] base_step = 32'd100, fast_step = 32'd25;
    logic [31:0] cmp_value;
    logic        cmp_enable;
    logic [15:0] flag_word;
    logic        flag_valid;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_q[$];

    // reference state
    logic [31:0] m_cmp = '0;
    logic        m_armed = 1'b0;
    logic [7:0]  m_last = '0;
    logic [31:0] m_pcnt = '0;

    always #2.5 clk = ~clk;

    rtc_tick_emulator u0 (
        .clk(clk), .rst_n(rst_n), .count_now(count_now),
        .tod_hour(tod_hour), .tod_min(tod_min), .tod_sec(tod_sec),
        .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
        .alarm_hour(alarm_hour), .alarm_min(alarm_min), .alarm_sec(alarm_sec),
        .rate_log2(rate_log2), .base_step(base_step), .fast_step(fast_step),
        .cmp_value(cmp_value), .cmp_enable(cmp_enable),
        .flag_word(flag_word), .flag_valid(flag_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cur_step();
        return (en_periodic && rate_log2 > 4'd6) ? fast_step : base_step;
    endfunction

    // monitor: pops one expected word per strobe
    always @(negedge clk) begin
        if (rst_n && flag_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected strobe", {16'h0, flag_word}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(flag_word == e, "R5/R6/R7/R8/R9 flag word", {16'h0, flag_word}, {16'h0, e});
            end
        end
    end

    task automatic set_en(input bit u, input bit a, input bit p);
        bit was_any;
        @(negedge clk);
        was_any = en_update || en_alarm || en_periodic;
        en_update = u; en_alarm = a; en_periodic = p;
        if (!p) m_pcnt = '0;
        if (!was_any && (u || a || p)) begin
            m_cmp = count_now + cur_step();
            m_armed = 1'b1;
        end
        if (!(u || a || p)) m_armed = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // driver: applies one counter value, predicts and queues the result
    task automatic tick(input logic [31:0] cval, input logic [7:0] s);
        int adds;
        logic [31:0] lost, sum, lim;
        int r;
        bit uf, af, pf;
        @(negedge clk);
        count_now = cval;
        tod_sec = s;
        if (m_armed && !$signed(cval - m_cmp) [31]) begin
            adds = 0;
            do begin
                m_cmp = m_cmp + cur_step();
                adds++;
            end while (!$signed(cval - m_cmp) [31] && (cval != m_cmp));
            lost = 32'(adds - 1);
            uf = en_update && (s != m_last);
            if (uf) m_last = s;
            af = en_alarm && (tod_hour == alarm_hour) && (tod_min == alarm_min) && (s == alarm_sec);
            pf = 1'b0;
            if (en_periodic) begin
                r = (rate_log2 == 0) ? 1 : int'(rate_log2);
                lim = (r > 6) ? 32'd1 : (32'd1 << (6 - r));
                sum = m_pcnt + lost + 32'd1;
                pf = (sum >= lim);
                m_pcnt = pf ? 32'd0 : sum;
            end
            if (uf || af || pf)
                exp_q.push_back({8'd1, 1'b1, pf, af, uf, 4'b0});
        end
        repeat (30) @(negedge clk);
        check(cmp_value == m_cmp, "R4 comparator after tick", cmp_value, m_cmp);
        check(exp_q.size() == 0, "R9 expected strobe missing", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmp_enable == 1'b0, "R1 channel off", {31'h0, cmp_enable}, 32'h0);
        check(flag_valid == 1'b0, "R1 no strobe", {31'h0, flag_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        count_now = 32'd1000;
        set_en(1'b1, 1'b0, 1'b0);
        check(cmp_enable == 1'b1, "R2 channel armed", {31'h0, cmp_enable}, 32'h1);
        check(cmp_value == 32'd1100, "R2 arm value", cmp_value, 32'd1100);

        tick(32'd1100, 8'd5);          // R5 update fires
        tick(32'd1200, 8'd5);          // R5 same seconds, nothing
        tick(32'd1250, 8'd6);          // R4 not due, comparator unchanged
        check(cmp_value == 32'd1300, "R4 not due keeps value", cmp_value, 32'd1300);

        rate_log2 = 4'd5;
        set_en(1'b1, 1'b0, 1'b1);
        tick(32'd1550, 8'd6);          // R4 two lost ticks, R7 limit 2 reached
        rate_log2 = 4'd6;
        tick(32'd1600, 8'd6);          // R7 limit 1
        rate_log2 = 4'd2;
        tick(32'd1700, 8'd6);          // R7 limit 16, count 1
        tick(32'd2150, 8'd6);          // R7 lost ticks accumulate

        alarm_hour = 8'd12; alarm_min = 8'd30; alarm_sec = 8'd45;
        tod_hour = 8'd12; tod_min = 8'd30;
        set_en(1'b1, 1'b1, 1'b1);
        tick(32'd2200, 8'd44);         // R5 only
        tick(32'd2300, 8'd45);         // R6 alarm plus update
        set_en(1'b0, 1'b0, 1'b1);
        tick(32'd2400, 8'd45);         // R6 alarm match ignored while disabled

        rate_log2 = 4'd8;
        tick(32'd2500, 8'd45);         // R8 fast step, every tick periodic
        tick(32'd2525, 8'd45);         // R8
        check(cmp_value == 32'd2550, "R8 fast step used", cmp_value, 32'd2550);

        set_en(1'b0, 1'b0, 1'b0);
        check(cmp_enable == 1'b0, "R3 channel off", {31'h0, cmp_enable}, 32'h0);
        tick(32'd2600, 8'd50);         // R3 no tick while off

        count_now = 32'hFFFF_FF80;
        set_en(1'b1, 1'b0, 1'b0);
        check(cmp_value == 32'hFFFF_FFE4, "R2 rearm value", cmp_value, 32'hFFFF_FFE4);
        tick(32'hFFFF_FFD0, 8'd51);    // R4 not yet due
        tick(32'h0000_0020, 8'd52);    // R4 wrap through zero

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule